// File: doc/BRIEF.md
# FSK Zero-Crossing Tone Demodulator

This block turns a squared two-tone FSK receive signal back into NRZ data. Its input is the one-bit output of an external comparator, which carries either the 1200 Hz mark tone or the 2200 Hz space tone. The block runs from a 460.8 kHz clock.

The input first passes through a synchronizer. The block then counts clocks between consecutive rising edges and, separately, between consecutive falling edges. Each completed period is compared against a threshold that sits midway between the mark period (384 clocks) and the space period (about 209 clocks). Both edge polarities feed one decision register, so the data estimate is refreshed every half cycle of the tone.

The output is held at the idle mark level whenever the external carrier detect input is low. It is also held at mark while the local transmitter is active. During transmit, measurement stops and both period meters are disarmed, which gives half-duplex operation.

Top module: `fsk_zc_demod`

## Requirements
- R1: After reset, with carrier present and the transmitter idle, `rxd_o` is 1 (mark).
- R2: The comparator input passes through a two-flop synchronizer. When an input transition is applied in cycle n, the resulting decision appears on `rxd_o` in cycle n+3, and the old value is still present in cycle n+2.
- R3: At each rising edge, the period since the previous rising edge decides the output. A period of 297 clocks or more gives 1 (mark). A period of fewer than 297 clocks gives 0 (space).
- R4: At each falling edge, the period since the previous falling edge decides the output by the same rule, so the output can change every half tone cycle.
- R5: A period meter gives no decision on the first edge of its polarity after reset or after transmit ends. It needs a previous edge of the same polarity.
- R6: While `carrier_i` is 0, `rxd_o` is 1 in the same cycle. Measurement continues, so the current decision shows again as soon as `carrier_i` returns to 1.
- R7: While `rts_ni` is 0 (transmitting), `rxd_o` is 1 and edges are ignored. On return to receive, the decision restarts at mark and both meters are disarmed.
- R8: Period counters saturate at their maximum (1023 clocks by default) and do not wrap. A gap longer than the counter range is therefore classified as mark.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 460.8 kHz clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_sq_i | input | 1 | Squared receive tone from the comparator (asynchronous) |
| carrier_i | input | 1 | Carrier detect from the separate detector block; 1 means a valid carrier |
| rts_ni | input | 1 | Active-low transmit request; 0 inhibits reception |
| rxd_o | output | 1 | Recovered NRZ data; 1 = mark |

## Verification
Each decision is due exactly three clocks after the input transition that completes its period. Of those, two clocks are spent in the synchronizer and one in the decision register. The driver records the cycle of every transition it applies, together with the period it closes. For each armed edge it queues the expected output at that cycle plus three, and also the previous value at plus two whenever the value flips. The monitor compares the output only on those due cycles.

The carrier and transmit gating is combinational, so these checks sample one time step after the gating input changes. Gating inputs are changed only after every queued result has been retired.

// File: rtl/fsk_zc_pkg.sv
package fsk_zc_pkg;
  localparam int unsigned NUM_EDGES = 2;
  localparam int unsigned EDGE_RISE = 0;
  localparam int unsigned EDGE_FALL = 1;

  // Rounded midpoint between the mark and space periods, in clocks
  function automatic int unsigned mid_period(input int unsigned clk_hz,
                                             input int unsigned mark_hz,
                                             input int unsigned space_hz);
    return (clk_hz / mark_hz + clk_hz / space_hz + 1) / 2;
  endfunction
endpackage

// File: rtl/fsk_zc_sync.sv
module fsk_zc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic rise_o,
  output logic fall_o
);
  // pipe[STAGES-1] is the synchronized level, pipe[STAGES] its previous value
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-1:0], rx_i};
  end

  assign rise_o =  pipe_q[STAGES-1] & ~pipe_q[STAGES];
  assign fall_o = ~pipe_q[STAGES-1] &  pipe_q[STAGES];

  if (STAGES == 2) begin : g_chk
    a_r2_rise_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o |-> $past(rx_i, 2));
    a_r2_fall_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fall_o |-> !$past(rx_i, 2));
  end
endmodule

// File: rtl/fsk_zc_meter.sv
module fsk_zc_meter #(
  parameter int unsigned CNT_W = 10,
  parameter int unsigned THR   = 297
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inhibit_i,
  input  logic edge_i,
  output logic hit_o,
  output logic mark_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  // Counter holds period-1 when the closing edge arrives
  localparam logic [CNT_W-1:0] THR_M1  = CNT_W'(THR - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (inhibit_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (edge_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else if (cnt_q != CNT_MAX) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign hit_o  = edge_i & armed_q & ~inhibit_i;
  assign mark_o = (cnt_q >= THR_M1);

  a_r8_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !edge_i && !inhibit_i) |=> (cnt_q == CNT_MAX));
  a_r5_arm_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_q) |-> $past(edge_i));
endmodule

// File: rtl/fsk_zc_demod.sv
module fsk_zc_demod
  import fsk_zc_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 460800,
  parameter int unsigned MARK_HZ     = 1200,
  parameter int unsigned SPACE_HZ    = 2200,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_sq_i,
  input  logic carrier_i,
  input  logic rts_ni,
  output logic rxd_o
);
  localparam int unsigned MARK_CLKS = CLK_HZ / MARK_HZ;
  localparam int unsigned THR       = mid_period(CLK_HZ, MARK_HZ, SPACE_HZ);
  localparam int unsigned CNT_W     = $clog2(2 * MARK_CLKS);

  logic                 inhibit;
  logic [NUM_EDGES-1:0] edge_vec, hit, mark;
  logic                 dec_q;

  assign inhibit = ~rts_ni;

  fsk_zc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rx_i   (rx_sq_i),
    .rise_o (edge_vec[EDGE_RISE]),
    .fall_o (edge_vec[EDGE_FALL])
  );

  for (genvar g = 0; g < NUM_EDGES; g++) begin : g_meter
    fsk_zc_meter #(.CNT_W(CNT_W), .THR(THR)) u_meter (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .inhibit_i (inhibit),
      .edge_i    (edge_vec[g]),
      .hit_o     (hit[g]),
      .mark_o    (mark[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              dec_q <= 1'b1;
    else if (inhibit)         dec_q <= 1'b1;
    else if (hit[EDGE_RISE])  dec_q <= mark[EDGE_RISE];
    else if (hit[EDGE_FALL])  dec_q <= mark[EDGE_FALL];
  end

  assign rxd_o = (carrier_i && rts_ni) ? dec_q : 1'b1;

  a_r4_edge_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(edge_vec));
  a_r7_tx_no_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inhibit |-> !(|hit));
  a_r7_mark_after_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rts_ni) |-> dec_q);
  a_r3_hold_no_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(|hit) && !inhibit) |=> $stable(dec_q));
endmodule

// File: tb/sim_fsk_zc_demod.sv
module sim_fsk_zc_demod;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rx = 1'b0;
  logic cd = 1'b1;
  logic rts_n = 1'b1;
  logic rxd;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  int    due_q[$];
  bit    val_q[$];
  string tag_q[$];

  int    last_t[2];
  bit    armed_m[2];
  bit    cur_exp = 1'b1;
  bit    en_m = 1'b1;
  string force_tag = "";

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fsk_zc_demod u0 (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .rx_sq_i   (rx),
    .carrier_i (cd),
    .rts_ni    (rts_n),
    .rxd_o     (rxd)
  );

  task automatic chk(input string tag, input bit act, input bit exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: rxd=%0b expected %0b", tag, cyc, act, exp);
    end
  endtask

  function automatic bit gate(input bit b);
    return (cd && rts_n) ? b : 1'b1;
  endfunction

  task automatic push(input int due, input bit v, input string tag);
    due_q.push_back(due);
    val_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  // Applies a transition in the current cycle and queues the result
  task automatic drive_edge(input bit v);
    int    k;
    bit    e;
    string t;
    k = v ? 0 : 1;
    rx = v;
    if (en_m) begin
      if (armed_m[k]) begin
        e = (cyc - last_t[k]) >= 297;
        t = (force_tag != "") ? force_tag : (v ? "R3" : "R4");
        if (e != cur_exp) push(cyc + 2, gate(cur_exp), "R2");
        push(cyc + 3, gate(e), t);
        cur_exp = e;
      end
      armed_m[k] = 1'b1;
      last_t[k]  = cyc;
    end
  endtask

  task automatic tone(input int hi, input int lo, input int n);
    repeat (n) begin
      drive_edge(1'b1);
      repeat (hi) @(negedge clk);
      drive_edge(1'b0);
      repeat (lo) @(negedge clk);
    end
  endtask

  task automatic drain();
    while (due_q.size() > 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic set_rts(input bit v);
    drain();
    rts_n = v;
    if (!v) en_m = 1'b0;
    else begin
      en_m = 1'b1;
      armed_m[0] = 1'b0;
      armed_m[1] = 1'b0;
      cur_exp = 1'b1;
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    while (due_q.size() > 0 && due_q[0] <= cyc) begin
      chk(tag_q[0], rxd, val_q[0]);
      void'(due_q.pop_front());
      void'(val_q.pop_front());
      void'(tag_q.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    armed_m[0] = 1'b0;
    armed_m[1] = 1'b0;
    last_t[0]  = 0;
    last_t[1]  = 0;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    #1 chk("R1", rxd, 1'b1);
    repeat (20) @(negedge clk);

    // R5: first rise and first fall give no decision
    drive_edge(1'b1);
    repeat (104) @(negedge clk);
    drive_edge(1'b0);
    repeat (104) @(negedge clk);
    chk("R5", rxd, 1'b1);

    tone(105, 104, 4);            // space
    tone(192, 192, 4);            // mark
    tone(105, 104, 3);            // space

    // R3 threshold boundary: 296 -> space, 297 -> mark
    force_tag = "R3";
    tone(148, 148, 3);
    tone(148, 149, 3);
    tone(148, 148, 3);
    force_tag = "";

    // R4 asymmetric duty, half-cycle updates
    tone(60, 340, 3);
    tone(30, 179, 3);
    tone(250, 50, 2);

    // R8: gap longer than counter range must read as mark
    tone(105, 104, 3);
    force_tag = "R8";
    drive_edge(1'b1);
    repeat (1100) @(negedge clk);
    drive_edge(1'b0);
    repeat (104) @(negedge clk);
    force_tag = "";
    tone(105, 104, 3);

    // R6: carrier gating
    drain();
    chk("R6", rxd, 1'b0);
    cd = 1'b0;
    #1 chk("R6", rxd, 1'b1);
    @(negedge clk);
    force_tag = "R6";
    tone(105, 104, 3);
    force_tag = "";
    drain();
    cd = 1'b1;
    #1 chk("R6", rxd, 1'b0);
    @(negedge clk);

    // R7: transmit inhibits reception
    tone(105, 104, 2);
    drain();
    chk("R7", rxd, 1'b0);
    set_rts(1'b0);
    #1 chk("R7", rxd, 1'b1);
    @(negedge clk);
    tone(105, 104, 4);
    repeat (6) @(negedge clk);
    set_rts(1'b1);
    #1 chk("R7", rxd, 1'b1);
    @(negedge clk);
    drive_edge(1'b1);
    repeat (104) @(negedge clk);
    drive_edge(1'b0);
    repeat (104) @(negedge clk);
    chk("R7", rxd, 1'b1);
    tone(105, 104, 3);
    drain();
    chk("R7", rxd, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule